// File: doc/BRIEF.md
# Immediate Override Register Unit

This unit sits between the 24-bit immediate field read from instruction memory and the immediate bus of an 8-bit datapath. Software often needs a 24-bit memory address or a 16-bit jump target that it has computed at run time, but it can only move one byte at a time. The unit holds three software-written bytes, one for each immediate byte. Writing the lowest byte arms a one-shot flag. On the next instruction, the whole outgoing immediate comes from the stored bytes and not from the instruction word.

The decoder raises one strobe per override-write instruction and presents the byte to store on a shared data bus. Software writes the upper bytes first, in any order, and the lowest byte last. The instruction that follows then executes with the composed value. The override lasts for that one instruction. The stored bytes persist, so a later override may rewrite only the bytes that change.

Top module: `imm_override`

## Requirements
- R1: An active-low asynchronous reset clears the armed flag and all three stored bytes. After reset the output follows the raw immediate. An override armed by writing only byte 0 (value V) then yields 0x0000VV.
- R2: While the flag is not armed, `eff_imm` equals `raw_imm` in the same cycle, with no register in the path.
- R3: A strobe on `ovr_wr[k]` at a rising clock edge stores `ovr_data` into stored byte k. Byte k occupies bits 8k+7..8k of the immediate, for k = 0, 1, 2.
- R4: A strobe on `ovr_wr[0]` at a rising edge arms the flag for the following cycle. In that cycle `eff_imm` equals {byte2, byte1, byte0}, and `raw_imm` has no effect on the output.
- R5: The flag stays armed for exactly one cycle. It stays armed for a further cycle only if `ovr_wr[0]` is strobed again during the armed cycle.
- R6: A stored byte keeps its value until its own strobe rewrites it. A second override that rewrites only byte 0 reuses the earlier bytes 1 and 2.
- R7: An override-write instruction executed in an armed cycle sees the overridden immediate. The value it writes becomes visible only from the next cycle.
- R8: Strobes on `ovr_wr[1]` or `ovr_wr[2]` alone never arm the flag. In the cycle after such a write, the output still equals `raw_imm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_imm | input | 24 | Immediate field from instruction memory |
| ovr_wr | input | 3 | One-hot strobes from the decoder; bit k writes stored byte k |
| ovr_data | input | 8 | Byte to store on a strobe |
| eff_imm | output | 24 | Effective immediate driven to the datapath |

## Verification
The properties assume two things. First, strobes and data are driven to known values on every cycle after reset is released. Second, any strobe seen while reset is low has no effect, so each property that looks back at a strobe qualifies it with the reset level in the same past cycle. The bench keeps within these limits: it drives every input only on falling edges, with at most one instruction's strobe per cycle (a single override instruction), and it releases reset with all strobes low. The bench sweeps all 256 byte values through every byte slot. It pairs each with a changing raw immediate, so an output taken from the wrong source or the wrong byte position shows up as a miscompare.

// File: rtl/imm_override.sv
module imm_override #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BYTE_W*NBYTES-1:0] raw_imm,
  input  logic [NBYTES-1:0]        ovr_wr,
  input  logic [BYTE_W-1:0]        ovr_data,
  output logic [BYTE_W*NBYTES-1:0] eff_imm
);
  localparam int IMM_W = BYTE_W * NBYTES;

  logic [IMM_W-1:0] held;
  logic             armed;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held[k*BYTE_W +: BYTE_W] <= '0;
      else if (ovr_wr[k]) held[k*BYTE_W +: BYTE_W] <= ovr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= ovr_wr[0];
  end

  assign eff_imm = armed ? held : raw_imm;
endmodule

// File: rtl/imm_override_chk.sv
module imm_override_chk #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [BYTE_W*NBYTES-1:0] raw_imm,
  input logic [NBYTES-1:0]        ovr_wr,
  input logic [BYTE_W-1:0]        ovr_data,
  input logic [BYTE_W*NBYTES-1:0] eff_imm
);
  localparam int IMM_W = BYTE_W * NBYTES;

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n && ovr_wr[0]) |-> eff_imm == raw_imm); // R2

  AST_LOW_BYTE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && ovr_wr[0]) |-> eff_imm[BYTE_W-1:0] == $past(ovr_data)); // R4

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(ovr_wr[0], 2) &&
     $past(ovr_wr == NBYTES'(1))) |-> $stable(eff_imm[IMM_W-1:BYTE_W])); // R6

  AST_UPPER_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !ovr_wr[0] && (ovr_wr != '0)) |-> eff_imm == raw_imm); // R8
endmodule

bind imm_override imm_override_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_imm(raw_imm), .ovr_wr(ovr_wr),
  .ovr_data(ovr_data), .eff_imm(eff_imm)
);

// File: tb/sim_imm_override.sv
module sim_imm_override;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] raw_imm = '0;
  logic [2:0]  ovr_wr = '0;
  logic [7:0]  ovr_data = '0;
  logic [23:0] eff_imm;

  int vecs = 0;
  int errs = 0;
  logic [7:0] mb [3];
  logic       marm;

  imm_override u0 (.clk(clk), .rst_n(rst_n), .raw_imm(raw_imm), .ovr_wr(ovr_wr),
                   .ovr_data(ovr_data), .eff_imm(eff_imm));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [23:0] exp, input string tag);
    vecs++;
    if (eff_imm !== exp) begin
      errs++;
      $display("FAIL %s: eff_imm=%06h expected=%06h", tag, eff_imm, exp);
    end
  endtask

  task automatic step(input logic [23:0] raw, input logic [2:0] wr,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    raw_imm = raw; ovr_wr = wr; ovr_data = d;
    #1;
    check(marm ? {mb[2], mb[1], mb[0]} : raw, tag);
    @(posedge clk);
    for (int k = 0; k < 3; k++) if (wr[k]) mb[k] = d;
    marm = wr[0];
  endtask

  task automatic do_reset(input logic [23:0] raw);
    @(negedge clk);
    rst_n = 1'b0; ovr_wr = '0; raw_imm = raw;
    for (int k = 0; k < 3; k++) mb[k] = '0;
    marm = 1'b0;
    #1;
    check(raw, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog: run did not complete, expected end of stimulus");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    do_reset(24'hABCDEF);
    step(24'h123456, 3'b000, 8'h00, "R1 pass after reset");
    step(24'h111111, 3'b001, 8'h5A, "R2 pass while writing");
    step(24'h222222, 3'b000, 8'h00, "R1 cleared upper bytes");
    step(24'h333333, 3'b000, 8'h00, "R5 flag dropped");

    for (int i = 0; i < 256; i++) begin
      logic [7:0] b = 8'(i);
      logic [23:0] r = 24'(i * 40503 + 7);
      step(r, 3'b100, b, "R8 byte2 write no arm");
      step(~r, 3'b010, ~b, "R8 byte1 write no arm");
      step(r ^ 24'h5A5A5A, 3'b001, b ^ 8'h3C, "R3 byte0 write pass");
      step(r + 24'h010101, 3'b000, 8'h00, "R4 override applied");
      step(r - 24'h000101, 3'b000, 8'h00, "R5 one cycle only");
    end

    step(24'h010203, 3'b010, 8'hC3, "R8 byte1 first");
    step(24'h040506, 3'b100, 8'h7E, "R8 byte2 second");
    step(24'h070809, 3'b001, 8'h11, "R3 byte0 last");
    step(24'hFFFFFF, 3'b000, 8'h00, "R4 expect 7EC311");
    step(24'h0A0B0C, 3'b001, 8'h99, "R6 rewrite only byte0");
    step(24'h000000, 3'b000, 8'h00, "R6 reuse bytes 1 and 2");

    step(24'h123123, 3'b001, 8'h44, "R5 arm again");
    step(24'hDEAD00, 3'b001, 8'h55, "R5 armed by back-to-back write");
    step(24'hBEEF00, 3'b010, 8'h66, "R7 write while armed is overridden");
    step(24'hCAFE00, 3'b000, 8'h00, "R7 flag gone");
    step(24'h424242, 3'b001, 8'h77, "R7 rearm");
    step(24'h434343, 3'b000, 8'h00, "R7 new byte1 visible");

    do_reset(24'h0F0F0F);
    step(24'h5555AA, 3'b001, 8'hE1, "R1 arm after mid-run reset");
    step(24'hAAAA55, 3'b000, 8'h00, "R1 upper bytes cleared");
    step(24'h135790, 3'b000, 8'h00, "R2 pass final");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule